// File: doc/BRIEF.md
# Low-Power Mode and Reset Controller

This block sits beside a small microcontroller core. It turns the raw external reset pin into a clean internal reset and sequences the two low-power states that software can request. The external pin is synchronised to the oscillator clock and must stay high for two whole machine cycles before the core is reset. A short glitch never resets the core.

Software requests a mode by writing a two-bit power-control value. In the light-sleep state only the CPU clock is stopped. Timers, the serial port, interrupt logic and RAM keep their clock, and any enabled pending interrupt or a reset brings the CPU back. In the deep-sleep state the oscillator is switched off. Interrupts have no effect there, and only a recognised hardware reset ends it. A reset that ends light sleep lets the CPU run again straight away, and internal RAM writes are held off until the internal reset takes over. Ports are left alone. When the lock input is set, the external-access strap is captured while reset is active, and that captured value is used afterwards.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: `core_rst` rises on the (2*MC_CLKS+2)-th rising edge that counts from the first edge sampling `rst_pin` high, provided the pin stays high for at least 2*MC_CLKS such edges. A high pulse of fewer edges never asserts it. After the pin is seen low, `core_rst` falls on the second following edge after that one.
- R2: While `rst_n` is low at a rising edge, all state clears. `core_rst` and `ram_wr_inhibit` are 0, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and the captured strap is 0.
- R3: A `pcon_we` write with `pcon_wdata[0]`=1 and `pcon_wdata[1]`=0 enters light sleep. From the next edge `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R4: In light sleep, `irq_pend` high at an edge (with the reset pin inactive) makes `cpu_clk_en`=1 after that edge.
- R5: A write with `pcon_wdata[1]`=1 enters deep sleep whatever bit 0 holds. From the next edge `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R6: In deep sleep, `irq_pend` and power-control writes have no effect. `osc_en` equals the synchronised reset pin, which lags by two edges. Only a recognised reset returns all enables to 1.
- R7: In light sleep, two edges after `rst_pin` is sampled high, `cpu_clk_en` and `ram_wr_inhibit` become 1. `ram_wr_inhibit` falls when `core_rst` rises. If the pin falls before recognition, `ram_wr_inhibit` clears two edges after the low sample and the CPU keeps running.
- R8: Power-control writes while `core_rst` is high are ignored, and reset leaves the block in the running state.
- R9: With `lock1`=0, `ea_out` follows `ea_pin`. With `lock1`=1, `ea_out` holds the `ea_pin` value from the last edge at which `core_rst` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low power-on clear of this block |
| rst_pin | input | 1 | Raw external reset pin, active high, asynchronous |
| pcon_we | input | 1 | Power-control register write strobe |
| pcon_wdata | input | 2 | Write data: bit 0 light sleep, bit 1 deep sleep |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ea_pin | input | 1 | External-access strap pin |
| lock1 | input | 1 | Lock bit: use the strap captured in reset |
| core_rst | output | 1 | Internal synchronous reset to the core, active high |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| ea_out | output | 1 | External-access value used by the core |

## Verification
The assertions assume that `pcon_we`, `irq_pend`, `ea_pin` and `lock1` change only away from the clock edge. They also assume that `rst_pin` is the only asynchronous input, so the checks read its synchronised copy and never the raw pin. The bench drives every input one time unit after a rising edge and samples outputs at that same point. It holds each reset pulse for a known number of edges, either clearly above or clearly below the two-machine-cycle threshold. In the pin-fall checks, the pin is brought low just after the edge that the latency is counted from.

// File: rtl/pwr_rst_pkg.sv
// Shared types for the low-power mode and reset controller.
// Assumes: nothing beyond the standard language.
package pwr_rst_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,  // CPU and peripherals clocked
        PM_LIGHT = 2'd1,  // CPU clock gated, peripherals running
        PM_WAKE  = 2'd2,  // reset seen during light sleep, RAM writes held off
        PM_DEEP  = 2'd3   // oscillator off until reset is recognised
    } pm_state_e;
endpackage

// File: rtl/rst_filter.sv
// Synchronises the raw reset pin and asserts the internal reset once the
// synchronised level has stayed high for HOLD_CLKS consecutive clocks.
// Assumes: rst_pin is asynchronous; rst_n is a synchronous active-low clear.
module rst_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CLKS   = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    output logic pin_sync,
    output logic core_rst
);
    localparam int CW = $clog2(HOLD_CLKS + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CLKS);

    logic [SYNC_STAGES-1:0] stage_q;
    logic [CW-1:0]          hold_cnt;

    // Synchroniser chain, one flop per stage.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage captures the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= rst_pin;
                end
            end else begin : g_next
                // Later stages pass the level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[SYNC_STAGES-1];

    // Duration counter: counts high clocks, saturates, clears on a low.
    always_ff @(posedge clk) begin
        if (!rst_n)             hold_cnt <= '0;
        else if (!pin_sync)     hold_cnt <= '0;
        else if (hold_cnt != HOLD_V) hold_cnt <= hold_cnt + 1'b1;
    end

    assign core_rst = (hold_cnt == HOLD_V);

    // R1: the reset can only start after the synchronised pin was high
    a_r1_rise_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> $past(pin_sync));
    // R1: a low synchronised pin ends the reset on the next edge
    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sync |=> !core_rst);
endmodule

// File: rtl/pm_fsm.sv
// Low-power mode sequencer: decodes power-control writes, wakes on interrupt
// or reset, and drives the clock enables and the RAM write inhibit.
// Assumes: core_rst and pin_sync come from rst_filter in the same clock domain.
module pm_fsm
    import pwr_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_rst,
    input  logic       pin_sync,
    input  logic       pcon_we,
    input  logic [1:0] pcon_wdata,
    input  logic       irq_pend,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       ram_wr_inhibit
);
    pm_state_e state_q, state_d;

    // Next-state selection; a recognised reset always returns to running.
    always_comb begin
        state_d = state_q;
        if (core_rst) begin
            state_d = PM_RUN;
        end else begin
            case (state_q)
                PM_RUN: begin
                    if (pcon_we && pcon_wdata[1])      state_d = PM_DEEP;
                    else if (pcon_we && pcon_wdata[0]) state_d = PM_LIGHT;
                end
                PM_LIGHT: begin
                    if (pin_sync)      state_d = PM_WAKE;
                    else if (irq_pend) state_d = PM_RUN;
                end
                PM_WAKE:  if (!pin_sync) state_d = PM_RUN;
                default:  state_d = PM_DEEP;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    // Output decode from the current state.
    always_comb begin
        cpu_clk_en     = (state_q == PM_RUN) || (state_q == PM_WAKE);
        per_clk_en     = (state_q != PM_DEEP);
        osc_en         = (state_q != PM_DEEP) || pin_sync;
        ram_wr_inhibit = (state_q == PM_WAKE) && !core_rst;
    end

    // R6: deep sleep is left only through a recognised reset
    a_r6_deep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_DEEP && !core_rst) |=> state_q == PM_DEEP);
    // R4: a pending interrupt ends light sleep
    a_r4_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_LIGHT && irq_pend && !pin_sync && !core_rst) |=> cpu_clk_en);
    // R5: deep sleep wins when both request bits are written together
    a_r5_deep_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && !core_rst && pcon_we && pcon_wdata == 2'b11) |=> !osc_en || pin_sync);
    // R7: the RAM inhibit window only exists while the CPU is clocked
    a_r7_inhibit_runs: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_inhibit |-> cpu_clk_en);
    // R8: reset always lands in the running state
    a_r8_reset_runs: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> per_clk_en && (cpu_clk_en || pin_sync));
endmodule

// File: rtl/ea_capture.sv
// Captures the external-access strap while the internal reset is active and
// selects between the captured and the live value under the lock bit.
// Assumes: ea_pin is stable around reset release.
module ea_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic core_rst,
    input  logic ea_pin,
    input  logic lock1,
    output logic ea_out
);
    logic ea_q;

    // Sample the strap on every edge of an active reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        ea_q <= 1'b0;
        else if (core_rst) ea_q <= ea_pin;
    end

    assign ea_out = lock1 ? ea_q : ea_pin;

    // R9: with the lock set, the output holds the last strap seen in reset
    a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lock1 && !core_rst && $stable(lock1)) |=> $stable(ea_out) || !lock1);
endmodule

// File: rtl/pwr_rst_ctrl.sv
// Top of the low-power mode and reset controller: reset pin filter, mode
// sequencer and external-access strap capture.
// Assumes: one oscillator clock domain; MC_CLKS oscillator clocks per machine cycle.
module pwr_rst_ctrl #(
    parameter int MC_CLKS     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_pin,
    input  logic       pcon_we,
    input  logic [1:0] pcon_wdata,
    input  logic       irq_pend,
    input  logic       ea_pin,
    input  logic       lock1,
    output logic       core_rst,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       ram_wr_inhibit,
    output logic       ea_out
);
    localparam int HOLD_CLKS = 2 * MC_CLKS;

    logic pin_sync;

    rst_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .HOLD_CLKS  (HOLD_CLKS)
    ) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_pin (rst_pin),
        .pin_sync(pin_sync),
        .core_rst(core_rst)
    );

    pm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_rst      (core_rst),
        .pin_sync      (pin_sync),
        .pcon_we       (pcon_we),
        .pcon_wdata    (pcon_wdata),
        .irq_pend      (irq_pend),
        .cpu_clk_en    (cpu_clk_en),
        .per_clk_en    (per_clk_en),
        .osc_en        (osc_en),
        .ram_wr_inhibit(ram_wr_inhibit)
    );

    ea_capture u_ea (
        .clk     (clk),
        .rst_n   (rst_n),
        .core_rst(core_rst),
        .ea_pin  (ea_pin),
        .lock1   (lock1),
        .ea_out  (ea_out)
    );

    // R5: with the oscillator off nothing downstream is clocked
    a_r5_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en && !per_clk_en);
endmodule

// File: tb/pwr_rst_ctrl_test.sv
module pwr_rst_ctrl_test;
    localparam int MC   = 12;
    localparam int HOLD = 2 * MC;

    logic clk = 1'b0;
    logic rst_n = 1'b0, rst_pin = 1'b0, pcon_we = 1'b0, irq_pend = 1'b0;
    logic ea_pin = 1'b0, lock1 = 1'b0;
    logic [1:0] pcon_wdata = 2'b00;
    logic core_rst, cpu_clk_en, per_clk_en, osc_en, ram_wr_inhibit, ea_out;
    int checks = 0, errors = 0;

    // {wdata[1:0], after write: cpu,per,osc, after irq pulse: cpu,per,osc}
    localparam logic [7:0] VEC [5] = '{
        8'b01_011_111,  // R3/R4 light sleep, interrupt wakes
        8'b10_000_000,  // R5/R6 deep sleep, interrupt ignored
        8'b11_000_000,  // R5 both bits: deep sleep wins
        8'b00_111_111,  // no request: stays running
        8'b01_011_111   // R3 light sleep again after a reset
    };

    pwr_rst_ctrl #(.MC_CLKS(MC)) uut (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .pcon_we(pcon_we),
        .pcon_wdata(pcon_wdata), .irq_pend(irq_pend), .ea_pin(ea_pin),
        .lock1(lock1), .core_rst(core_rst), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en),
        .ram_wr_inhibit(ram_wr_inhibit), .ea_out(ea_out)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic en3(input string req, input logic [2:0] exp);
        chk(req, {5'b0, cpu_clk_en, per_clk_en, osc_en}, {5'b0, exp});
    endtask

    task automatic full_reset();
        rst_pin = 1'b1;
        repeat (HOLD + 4) tick();
        rst_pin = 1'b0;
        repeat (4) tick();
    endtask

    task automatic write_pcon(input logic [1:0] d);
        pcon_we = 1'b1; pcon_wdata = d;
        tick();
        pcon_we = 1'b0; pcon_wdata = 2'b00;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic seen;
        repeat (3) tick();
        // R2 reset state
        en3("R2 enables", 3'b111);
        chk("R2 core_rst", {7'b0, core_rst}, 8'd0);
        chk("R2 inhibit", {7'b0, ram_wr_inhibit}, 8'd0);
        lock1 = 1'b1;
        chk("R2 ea capture cleared", {7'b0, ea_out}, 8'd0);
        lock1 = 1'b0;
        rst_n = 1'b1;
        tick();

        // Table walk: mode request, interrupt pulse, then a full reset
        for (int i = 0; i < 5; i++) begin
            write_pcon(VEC[i][7:6]);
            en3("R3/R5 after write", VEC[i][5:3]);
            irq_pend = 1'b1; tick(); irq_pend = 1'b0;
            en3("R4/R6 after irq", VEC[i][2:0]);
            full_reset();
            en3("R6/R8 after reset", 3'b111);
        end

        // R1 exact latency and release
        rst_pin = 1'b1;
        for (int i = 0; i < HOLD + 1; i++) begin
            tick();
            chk("R1 not yet", {7'b0, core_rst}, 8'd0);
        end
        tick();
        chk("R1 asserted", {7'b0, core_rst}, 8'd1);
        rst_pin = 1'b0;
        tick();
        chk("R1 still high j", {7'b0, core_rst}, 8'd1);
        tick();
        chk("R1 still high j+1", {7'b0, core_rst}, 8'd1);
        tick();
        chk("R1 released", {7'b0, core_rst}, 8'd0);

        // R1 short pulse never resets
        repeat (3) tick();
        rst_pin = 1'b1;
        repeat (HOLD - 1) tick();
        rst_pin = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < HOLD; i++) begin
            if (core_rst) seen = 1'b1;
            tick();
        end
        chk("R1 short pulse", {7'b0, seen}, 8'd0);

        // R6 deep sleep ignores writes, osc follows synchronised pin
        write_pcon(2'b10);
        write_pcon(2'b01);
        en3("R6 write ignored", 3'b000);
        rst_pin = 1'b1;
        tick(); en3("R6 osc off edge k", 3'b000);
        tick(); en3("R6 osc on edge k+1", 3'b001);
        rst_pin = 1'b0;
        repeat (3) tick();
        en3("R6 short pulse stays deep", 3'b000);
        full_reset();
        en3("R6 exit by reset", 3'b111);

        // R7 reset during light sleep, recognised
        write_pcon(2'b01);
        rst_pin = 1'b1;
        tick(); chk("R7 edge k", {6'b0, cpu_clk_en, ram_wr_inhibit}, 8'b00);
        tick(); chk("R7 edge k+1", {6'b0, cpu_clk_en, ram_wr_inhibit}, 8'b00);
        tick(); chk("R7 edge k+2", {6'b0, cpu_clk_en, ram_wr_inhibit}, 8'b11);
        repeat (HOLD - 2) tick();
        chk("R7 before reset", {6'b0, core_rst, ram_wr_inhibit}, 8'b01);
        tick();
        chk("R7 reset takes over", {6'b0, core_rst, ram_wr_inhibit}, 8'b10);
        // R8 write during reset ignored
        write_pcon(2'b10);
        rst_pin = 1'b0;
        repeat (4) tick();
        en3("R8 write in reset ignored", 3'b111);

        // R7 short pulse in light sleep: CPU keeps running
        write_pcon(2'b01);
        rst_pin = 1'b1;
        repeat (4) tick();
        rst_pin = 1'b0;
        tick();
        chk("R7 short j", {6'b0, cpu_clk_en, ram_wr_inhibit}, 8'b11);
        tick();
        chk("R7 short j+1", {6'b0, cpu_clk_en, ram_wr_inhibit}, 8'b11);
        tick();
        chk("R7 short cleared", {6'b0, cpu_clk_en, ram_wr_inhibit}, 8'b10);

        // R9 strap capture
        ea_pin = 1'b1;
        full_reset();
        ea_pin = 1'b0;
        lock1 = 1'b1;
        tick();
        chk("R9 locked holds", {7'b0, ea_out}, 8'd1);
        lock1 = 1'b0;
        #1;
        chk("R9 unlocked follows", {7'b0, ea_out}, 8'd0);
        full_reset();
        ea_pin = 1'b1;
        lock1 = 1'b1;
        #1;
        chk("R9 locked new capture", {7'b0, ea_out}, 8'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule